// File: doc/BRIEF.md
# Error-Corrected Flash Array Controller

This block holds a small behavioural flash array and serves it through two paths. A one-cycle read port returns words to a bus. It repairs any single flipped bit in the stored codeword and reports a bus error when the damage cannot be repaired. A command port runs page erase, page program, blank check and a diagnostic word read. Each command ends with a one-cycle completion strobe and an 8-bit status code.

Every word is stored with Hamming check bits and an overall parity bit, which together form a SECDED code. The encoder inverts two check bits. As a result, the erased pattern (all stored bits zero, check bits included) decodes as an uncorrectable error. A location therefore cannot be read over the bus until it has been programmed. Program requests must start on a page boundary and cover whole pages. Program data is pulled one word per cycle through a ready/data pair.

Top module: `ecc_flash_ctrl`

## Requirements
- R1: Reset leaves every stored bit at zero. An erase clears all data, check and parity bits of every word in the pages it covers. After reset, all response strobes are low.
- R2: A bus read with `rd_en` high returns `rd_valid` one cycle later. For a programmed, undamaged word it returns the programmed data with `rd_err` and `rd_fix` both low. Word k of a program command is written to byte address start+4k.
- R3: The codeword layout is: bits 31:0 data, bits 37:32 check, bit 38 overall parity. `prog_flip` is XORed into the codeword as it is written. A single flipped bit anywhere in the codeword is corrected on a bus read: the original data is returned with `rd_fix` high and `rd_err` low.
- R4: Two flipped codeword bits make a bus read return `rd_err` high and `rd_fix` low.
- R5: A bus read of an erased, never-programmed word returns `rd_err` high.
- R6: Blank check (op 2) completes with status 0 only if every stored bit of the covered pages is zero, check bits included. Otherwise it completes with status 103.
- R7: A program command (op 1) whose start address or byte length is not a multiple of 512 completes in the next cycle with status 101. It never raises `prog_rdy` and leaves the array unchanged.
- R8: The diagnostic read (op 3) completes with status 0 in the next cycle. It returns the raw stored data bits on `cmd_rdata` and the uncorrectable flag on `cmd_rerr`. It never drives `rd_valid` or `rd_err`.
- R9: A command arriving while `cmd_busy` is high is dropped. It produces `rej_done` with `rej_status` = 102 one cycle later, and the running command completes normally.
- R10: Op encodings are 0 erase, 1 program, 2 blank check, 3 read. A successful command reports status 0. Program and erase run one word per cycle, and `cmd_done` follows the last word by one cycle.
- R11: Erase and blank check cover `cmd_len`/512 whole pages, starting at the page that holds `cmd_addr`; the offset within the page is ignored. A zero page count completes in the next cycle with status 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Bus read request |
| rd_addr | input | 11 | Bus read byte address |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 32 | Corrected read data |
| rd_err | output | 1 | Uncorrectable error (bus error) |
| rd_fix | output | 1 | Single-bit error was corrected |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Command opcode |
| cmd_addr | input | 11 | Command byte address |
| cmd_len | input | 12 | Command byte length |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | Command completion strobe |
| cmd_status | output | 8 | Completion status code |
| cmd_rdata | output | 32 | Raw data from diagnostic read |
| cmd_rerr | output | 1 | Uncorrectable flag from diagnostic read |
| rej_done | output | 1 | Rejected-command strobe |
| rej_status | output | 8 | Rejection code |
| prog_rdy | output | 1 | Program data is consumed this cycle |
| prog_data | input | 32 | Program data word |
| prog_flip | input | 39 | Codeword fault-injection mask |

## Verification
The bench targets the corner cases where an ECC scheme usually goes wrong:
- **Erased words.** A plain Hamming code would accept the all-zero word as valid zero data. Such a design would return zeros for erased words instead of a bus error.
- **Single flips outside the data field.** Single flips are injected in the check field and in the overall parity bit. A decoder that only repairs data positions would flag these as uncorrectable.
- **Blank check on zero data.** A page programmed with all-zero data must fail blank check. A design that checks only the data bits would pass it.
- **Misaligned program and busy overlap.** A misaligned program must leave the earlier contents readable and untouched. A command issued during a long erase must be rejected, not silently lost.

// File: rtl/flc_pkg.sv
package flc_pkg;

   typedef enum logic [1:0] {
      OP_ERASE = 2'd0,
      OP_PROG  = 2'd1,
      OP_BLANK = 2'd2,
      OP_READ  = 2'd3
   } flc_op_e;

   localparam logic [7:0] ST_OK       = 8'd0;
   localparam logic [7:0] ST_ALIGN    = 8'd101;
   localparam logic [7:0] ST_BUSY     = 8'd102;
   localparam logic [7:0] ST_NOTBLANK = 8'd103;

   // number of Hamming check bits needed for dw data bits
   function automatic int chk_bits(input int dw);
      int k;
      k = 1;
      while ((1 << k) < dw + k + 1) k++;
      return k;
   endfunction

   // syndrome value assigned to data bit i: i-th integer >= 3 that is not a power of two
   function automatic int hpos(input int i);
      int n;
      int r;
      n = 0;
      r = 0;
      for (int p = 3; p < 256; p++) begin
         if ((p & (p - 1)) != 0) begin
            if (n == i) r = p;
            n++;
         end
      end
      return r;
   endfunction

   // data bits that feed check bit j
   function automatic logic [63:0] col_mask(input int dw, input int j);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < dw; i++) m[i] = ((hpos(i) >> j) & 1) != 0;
      return m;
   endfunction

endpackage

// File: rtl/flc_ecc_enc.sv
module flc_ecc_enc
   import flc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CHK_W  = chk_bits(DATA_W),
   parameter int CW_W   = DATA_W + CHK_W + 1
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   cw
);
   // two inverted check bits keep the all-zero word off the code
   localparam logic [CHK_W-1:0] INV = CHK_W'(3);

   logic [CHK_W-1:0] chk;

   for (genvar j = 0; j < CHK_W; j++) begin : g_chk
      localparam logic [63:0] MASK = col_mask(DATA_W, j);
      assign chk[j] = ^(data & MASK[DATA_W-1:0]);
   end

   logic [CHK_W-1:0] chk_st;
   assign chk_st = chk ^ INV;
   assign cw     = {^{data, chk_st}, chk_st, data};

endmodule

// File: rtl/flc_ecc_dec.sv
module flc_ecc_dec
   import flc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CHK_W  = chk_bits(DATA_W),
   parameter int CW_W   = DATA_W + CHK_W + 1
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data,
   output logic              fixed,
   output logic              uncorr
);
   localparam logic [CHK_W-1:0] INV = CHK_W'(3);

   logic [DATA_W-1:0] raw;
   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] hit;
   logic              par_err;
   logic              syn_chk;
   logic              single_ok;

   assign raw = cw[DATA_W-1:0];

   for (genvar j = 0; j < CHK_W; j++) begin : g_syn
      localparam logic [63:0] MASK = col_mask(DATA_W, j);
      assign syn[j] = cw[DATA_W+j] ^ INV[j] ^ (^(raw & MASK[DATA_W-1:0]));
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_hit
      localparam logic [CHK_W-1:0] POS = CHK_W'(hpos(i));
      assign hit[i] = (syn == POS);
   end

   assign par_err   = ^cw;
   assign syn_chk   = (syn != '0) && ((syn & (syn - 1'b1)) == '0);
   assign single_ok = par_err && ((syn == '0) || syn_chk || (|hit));
   assign fixed     = single_ok;
   assign uncorr    = (par_err && !single_ok) || (!par_err && (syn != '0));
   assign data      = raw ^ (par_err ? hit : '0);

endmodule

// File: rtl/flc_array.sv
module flc_array #(
   parameter int WORDS = 512,
   parameter int CW_W  = 39,
   parameter int IDX_W = $clog2(WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [CW_W-1:0]  wdata,
   input  logic [IDX_W-1:0] ridx_a,
   output logic [CW_W-1:0]  rdata_a,
   input  logic [IDX_W-1:0] ridx_b,
   output logic [CW_W-1:0]  rdata_b
);
   logic [CW_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata_a = mem[ridx_a];
   assign rdata_b = mem[ridx_b];

endmodule

// File: rtl/ecc_flash_ctrl.sv
module ecc_flash_ctrl
   import flc_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int PAGE_BYTES = 512,
   parameter int NPAGES     = 4,
   parameter int ADDR_W     = $clog2(NPAGES * PAGE_BYTES),
   parameter int LEN_W      = ADDR_W + 1,
   parameter int CW_W       = DATA_W + chk_bits(DATA_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_err,
   output logic              rd_fix,
   input  logic              cmd_valid,
   input  logic [1:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   output logic              cmd_busy,
   output logic              cmd_done,
   output logic [7:0]        cmd_status,
   output logic [DATA_W-1:0] cmd_rdata,
   output logic              cmd_rerr,
   output logic              rej_done,
   output logic [7:0]        rej_status,
   output logic              prog_rdy,
   input  logic [DATA_W-1:0] prog_data,
   input  logic [CW_W-1:0]   prog_flip
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int WB_W       = $clog2(WORD_BYTES);
   localparam int PG_W       = $clog2(PAGE_BYTES);
   localparam int WPP_W      = PG_W - WB_W;
   localparam int WORDS      = NPAGES * PAGE_BYTES / WORD_BYTES;
   localparam int IDX_W      = $clog2(WORDS);
   localparam int CNT_W      = IDX_W + 1;

   if (DATA_W % 8 != 0 || DATA_W < 8 || DATA_W > 64)
      $error("DATA_W must be a whole number of bytes between 8 and 64");
   if ((PAGE_BYTES & (PAGE_BYTES - 1)) != 0 || PAGE_BYTES < 2 * WORD_BYTES)
      $error("PAGE_BYTES must be a power of two holding at least two words");
   if ((NPAGES & (NPAGES - 1)) != 0)
      $error("NPAGES must be a power of two");
   if (ADDR_W != $clog2(NPAGES * PAGE_BYTES) || LEN_W != ADDR_W + 1)
      $error("ADDR_W and LEN_W must keep their derived values");

   typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG, S_BLANK} state_e;

   state_e           state;
   logic [IDX_W-1:0] cur;
   logic [CNT_W-1:0] rem;
   logic             blank_bad;

   logic [IDX_W-1:0] cmd_word, page_first;
   logic [CNT_W-1:0] page_words, prog_words;
   logic             misalign;

   assign cmd_word   = cmd_addr[ADDR_W-1:WB_W];
   assign page_first = {cmd_addr[ADDR_W-1:PG_W], {WPP_W{1'b0}}};
   assign page_words = {cmd_len[LEN_W-1:PG_W], {WPP_W{1'b0}}};
   assign prog_words = cmd_len[LEN_W-1:WB_W];
   assign misalign   = (|cmd_addr[PG_W-1:0]) || (|cmd_len[PG_W-1:0]);

   logic [CW_W-1:0]   enc_cw, wr_cw, raw_a, raw_b;
   logic [DATA_W-1:0] dec_a_data, dec_b_data;
   logic              dec_a_fix, dec_a_unc, dec_b_fix, dec_b_unc;
   logic              we;

   assign we       = (state == S_ERASE) || (state == S_PROG);
   assign wr_cw    = (state == S_PROG) ? (enc_cw ^ prog_flip) : '0;
   assign prog_rdy = (state == S_PROG);
   assign cmd_busy = (state != S_IDLE);

   flc_ecc_enc #(.DATA_W(DATA_W)) u_enc (.data(prog_data), .cw(enc_cw));

   flc_array #(.WORDS(WORDS), .CW_W(CW_W), .IDX_W(IDX_W)) u_array (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (we),
      .widx   (cur),
      .wdata  (wr_cw),
      .ridx_a (rd_addr[ADDR_W-1:WB_W]),
      .rdata_a(raw_a),
      .ridx_b ((state == S_BLANK) ? cur : cmd_word),
      .rdata_b(raw_b)
   );

   flc_ecc_dec #(.DATA_W(DATA_W)) u_dec_bus (
      .cw(raw_a), .data(dec_a_data), .fixed(dec_a_fix), .uncorr(dec_a_unc));
   flc_ecc_dec #(.DATA_W(DATA_W)) u_dec_cmd (
      .cw(raw_b), .data(dec_b_data), .fixed(dec_b_fix), .uncorr(dec_b_unc));

   // bus read path
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
         rd_err   <= 1'b0;
         rd_fix   <= 1'b0;
      end else begin
         rd_valid <= rd_en;
         rd_err   <= rd_en && dec_a_unc;
         rd_fix   <= rd_en && dec_a_fix;
         if (rd_en) rd_data <= dec_a_data;
      end
   end

   // command sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         cur        <= '0;
         rem        <= '0;
         blank_bad  <= 1'b0;
         cmd_done   <= 1'b0;
         cmd_status <= ST_OK;
         cmd_rdata  <= '0;
         cmd_rerr   <= 1'b0;
         rej_done   <= 1'b0;
         rej_status <= ST_OK;
      end else begin
         cmd_done <= 1'b0;
         rej_done <= 1'b0;
         if (state == S_IDLE) begin
            if (cmd_valid) begin
               blank_bad <= 1'b0;
               unique case (flc_op_e'(cmd_op))
                  OP_ERASE, OP_BLANK: begin
                     if (page_words == '0) begin
                        cmd_done   <= 1'b1;
                        cmd_status <= ST_OK;
                     end else begin
                        cur   <= page_first;
                        rem   <= page_words;
                        state <= (cmd_op == OP_ERASE) ? S_ERASE : S_BLANK;
                     end
                  end
                  OP_PROG: begin
                     if (misalign || prog_words == '0) begin
                        cmd_done   <= 1'b1;
                        cmd_status <= misalign ? ST_ALIGN : ST_OK;
                     end else begin
                        cur   <= cmd_word;
                        rem   <= prog_words;
                        state <= S_PROG;
                     end
                  end
                  OP_READ: begin
                     cmd_rdata  <= raw_b[DATA_W-1:0];
                     cmd_rerr   <= dec_b_unc;
                     cmd_done   <= 1'b1;
                     cmd_status <= ST_OK;
                  end
               endcase
            end
         end else begin
            if (cmd_valid) begin
               rej_done   <= 1'b1;
               rej_status <= ST_BUSY;
            end
            cur       <= cur + 1'b1;
            rem       <= rem - 1'b1;
            blank_bad <= blank_bad || (state == S_BLANK && raw_b != '0);
            if (rem == CNT_W'(1)) begin
               state      <= S_IDLE;
               cmd_done   <= 1'b1;
               cmd_status <= (state == S_BLANK && (blank_bad || raw_b != '0))
                             ? ST_NOTBLANK : ST_OK;
            end
         end
      end
   end

endmodule

// File: rtl/flc_checker.sv
module flc_checker #(
   parameter int DATA_W     = 32,
   parameter int PAGE_BYTES = 512,
   parameter int ADDR_W     = 11,
   parameter int LEN_W      = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rd_valid,
   input logic              rd_err,
   input logic              rd_fix,
   input logic              cmd_valid,
   input logic [1:0]        cmd_op,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic [LEN_W-1:0]  cmd_len,
   input logic              cmd_busy,
   input logic              cmd_done,
   input logic [7:0]        cmd_status,
   input logic              rej_done,
   input logic [7:0]        rej_status,
   input logic              prog_rdy
);
   localparam int PG_W = $clog2(PAGE_BYTES);

   AST_RD_RESP_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid); // R2

   AST_NO_STRAY_BUSERR: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (!rd_valid && !rd_err)); // R8

   AST_FIX_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> !(rd_err && rd_fix)); // R4

   AST_MISALIGN_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_busy && cmd_op == 2'd1 &&
       ((|cmd_addr[PG_W-1:0]) || (|cmd_len[PG_W-1:0])))
      |=> (cmd_done && cmd_status == 8'd101 && !prog_rdy)); // R7

   AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_busy) |=> (rej_done && rej_status == 8'd102)); // R9

   AST_PROG_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      prog_rdy |-> cmd_busy); // R10

   AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_busy && cmd_op == 2'd3)
      |=> (cmd_done && cmd_status == 8'd0 && !cmd_busy)); // R8

endmodule

bind ecc_flash_ctrl flc_checker #(
   .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
) u_flc_checker (
   .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
   .rd_err(rd_err), .rd_fix(rd_fix), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
   .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_busy(cmd_busy),
   .cmd_done(cmd_done), .cmd_status(cmd_status), .rej_done(rej_done),
   .rej_status(rej_status), .prog_rdy(prog_rdy)
);

// File: tb/test_ecc_flash_ctrl.sv
module test_ecc_flash_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rd_en = 1'b0;
   logic [10:0] rd_addr = '0;
   logic        rd_valid;
   logic [31:0] rd_data;
   logic        rd_err, rd_fix;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [10:0] cmd_addr = '0;
   logic [11:0] cmd_len = '0;
   logic        cmd_busy, cmd_done;
   logic [7:0]  cmd_status;
   logic [31:0] cmd_rdata;
   logic        cmd_rerr, rej_done;
   logic [7:0]  rej_status;
   logic        prog_rdy;
   logic [31:0] prog_data = '0;
   logic [38:0] prog_flip = '0;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #4 clk = ~clk;

   ecc_flash_ctrl i_ecc_flash_ctrl (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err), .rd_fix(rd_fix),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
      .cmd_len(cmd_len), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
      .cmd_status(cmd_status), .cmd_rdata(cmd_rdata), .cmd_rerr(cmd_rerr),
      .rej_done(rej_done), .rej_status(rej_status), .prog_rdy(prog_rdy),
      .prog_data(prog_data), .prog_flip(prog_flip)
   );

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         errors++;
         $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   function automatic logic [31:0] pat(input int seed, input int k);
      return 32'(k + 1) * 32'h0100_0193 + 32'(seed) * 32'h9E37_79B9;
   endfunction

   task automatic check(input bit ok, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", what, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [1:0] op, input logic [10:0] addr,
                          input logic [11:0] len, input int seed, input bit zero,
                          input int fword, input logic [38:0] fmask,
                          output logic [7:0] st, output logic [31:0] rdat,
                          output logic rerr, output bit saw_rdy);
      int k;
      bit got;
      k = 0;
      got = 0;
      saw_rdy = 0;
      st = '0; rdat = '0; rerr = 1'b0;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = len;
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int n = 0; n < 5000 && !got; n++) begin
         if (cmd_done) begin
            got = 1; st = cmd_status; rdat = cmd_rdata; rerr = cmd_rerr;
         end else begin
            if (prog_rdy) begin
               saw_rdy = 1;
               prog_data = zero ? 32'h0 : pat(seed, k);
               prog_flip = (k == fword) ? fmask : '0;
               k++;
            end
            @(negedge clk);
         end
      end
      prog_flip = '0;
      check(got == 1, "R10 command completion seen", 64'(got), 64'd1);
   endtask

   task automatic bus_read(input logic [10:0] addr, output logic [31:0] d,
                           output logic e, output logic f, output logic v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = addr;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data; e = rd_err; f = rd_fix; v = rd_valid;
   endtask

   logic [7:0]  st;
   logic [31:0] rdat, d;
   logic        rerr, e, f, v;
   bit          sr;

   task automatic t_reset();
      check(!rd_valid && !cmd_done && !rej_done && !cmd_busy && !prog_rdy,
            "R1 strobes low after reset",
            64'({rd_valid, cmd_done, rej_done, cmd_busy, prog_rdy}), 64'd0);
      bus_read(11'h000, d, e, f, v);
      check(v && e && !f, "R5 erased word after reset gives bus error",
            64'({v, e, f}), 64'b110);
      bus_read(11'h7FC, d, e, f, v);
      check(e, "R1 last word erased after reset", 64'(e), 64'd1);
   endtask

   task automatic t_program();
      run_cmd(2'd1, 11'h200, 12'd512, 17, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0 && sr, "R10 program page 1 status", 64'({sr, st}), 64'h100);
      bus_read(11'h200, d, e, f, v);
      check(v && !e && !f && d == pat(17, 0), "R2 read word 0",
            64'({v, e, f, d}), 64'({3'b100, pat(17, 0)}));
      bus_read(11'h204, d, e, f, v);
      check(!e && !f && d == pat(17, 1), "R2 read word 1", 64'(d), 64'(pat(17, 1)));
      bus_read(11'h3FC, d, e, f, v);
      check(!e && d == pat(17, 127), "R2 read last word", 64'(d), 64'(pat(17, 127)));
   endtask

   task automatic t_zero_and_align();
      run_cmd(2'd0, 11'h200, 12'd0, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0, "R11 zero-length erase status", 64'(st), 64'd0);
      bus_read(11'h204, d, e, f, v);
      check(!e && d == pat(17, 1), "R11 zero-length erase leaves data",
            64'(d), 64'(pat(17, 1)));
      run_cmd(2'd1, 11'h204, 12'd512, 99, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd101 && !sr, "R7 misaligned start rejected",
            64'({sr, st}), 64'd101);
      bus_read(11'h204, d, e, f, v);
      check(!e && d == pat(17, 1), "R7 array unchanged after misaligned start",
            64'(d), 64'(pat(17, 1)));
      run_cmd(2'd1, 11'h400, 12'd8, 99, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd101 && !sr, "R7 short length rejected", 64'({sr, st}), 64'd101);
      bus_read(11'h400, d, e, f, v);
      check(e, "R7 target still erased after short length", 64'(e), 64'd1);
   endtask

   task automatic t_single();
      int bits [6] = '{0, 17, 31, 32, 37, 38};
      foreach (bits[n]) begin
         run_cmd(2'd0, 11'h400, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
         run_cmd(2'd1, 11'h400, 12'd512, n + 3, 0, 3, 39'(1) << bits[n],
                 st, rdat, rerr, sr);
         bus_read(11'h40C, d, e, f, v);
         check(!e && f && d == pat(n + 3, 3),
               $sformatf("R3 single flip at codeword bit %0d corrected", bits[n]),
               64'({e, f, d}), 64'({2'b01, pat(n + 3, 3)}));
      end
      bus_read(11'h410, d, e, f, v);
      check(!e && !f && d == pat(8, 4), "R2 neighbour word clean",
            64'({e, f, d}), 64'(pat(8, 4)));
   endtask

   task automatic t_double();
      run_cmd(2'd0, 11'h400, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      run_cmd(2'd1, 11'h400, 12'd512, 40, 0, 3, 39'h3, st, rdat, rerr, sr);
      bus_read(11'h40C, d, e, f, v);
      check(e && !f, "R4 double data flip flagged", 64'({e, f}), 64'b10);
      run_cmd(2'd3, 11'h40C, 12'd0, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0 && rerr && rdat == (pat(40, 3) ^ 32'h3),
            "R8 diagnostic read returns raw data and flag",
            64'({rerr, rdat}), 64'({1'b1, pat(40, 3) ^ 32'h3}));
      check(!rd_valid && !rd_err, "R8 diagnostic read raises no bus error",
            64'({rd_valid, rd_err}), 64'd0);
      run_cmd(2'd3, 11'h410, 12'd0, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(!rerr && rdat == pat(40, 4), "R8 diagnostic read of clean word",
            64'({rerr, rdat}), 64'(pat(40, 4)));
      run_cmd(2'd0, 11'h400, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      run_cmd(2'd1, 11'h400, 12'd512, 41, 0, 3, 39'h41_0000_0000, st, rdat, rerr, sr);
      bus_read(11'h40C, d, e, f, v);
      check(e && !f, "R4 check plus parity flip flagged", 64'({e, f}), 64'b10);
   endtask

   task automatic t_blank();
      run_cmd(2'd0, 11'h600, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0, "R1 erase page 3 status", 64'(st), 64'd0);
      run_cmd(2'd2, 11'h600, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0, "R6 blank check passes on erased page", 64'(st), 64'd0);
      run_cmd(2'd1, 11'h600, 12'd512, 0, 1, -1, '0, st, rdat, rerr, sr);
      run_cmd(2'd2, 11'h600, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd103, "R6 zero data still fails blank check", 64'(st), 64'd103);
      bus_read(11'h600, d, e, f, v);
      check(!e && d == 32'h0, "R2 programmed zero word reads cleanly",
            64'({e, d}), 64'd0);
      run_cmd(2'd0, 11'h600, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      run_cmd(2'd2, 11'h600, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0, "R6 blank again after erase", 64'(st), 64'd0);
      bus_read(11'h7FC, d, e, f, v);
      check(e, "R1 erased page gives bus error", 64'(e), 64'd1);
      run_cmd(2'd2, 11'h400, 12'd1024, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd103, "R11 two-page blank check sees page 2", 64'(st), 64'd103);
   endtask

   task automatic t_mid_page_erase();
      run_cmd(2'd0, 11'h250, 12'd512, 0, 0, -1, '0, st, rdat, rerr, sr);
      check(st == 8'd0, "R11 mid-page erase status", 64'(st), 64'd0);
      bus_read(11'h200, d, e, f, v);
      check(e, "R11 page start erased by mid-page address", 64'(e), 64'd1);
      bus_read(11'h3FC, d, e, f, v);
      check(e, "R11 page end erased by mid-page address", 64'(e), 64'd1);
   endtask

   task automatic t_busy();
      bit got;
      run_cmd(2'd1, 11'h000, 12'd512, 50, 0, -1, '0, st, rdat, rerr, sr);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd0; cmd_addr = 11'h000; cmd_len = 12'd1024;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 2'd3; cmd_addr = 11'h004;
      @(negedge clk);
      cmd_valid = 1'b0;
      check(rej_done && rej_status == 8'd102 && !cmd_done,
            "R9 command during erase rejected",
            64'({rej_done, cmd_done, rej_status}), 64'({2'b10, 8'd102}));
      got = 0;
      for (int n = 0; n < 3000 && !got; n++) begin
         if (cmd_done) begin
            got = 1;
            check(cmd_status == 8'd0, "R9 running erase completes normally",
                  64'(cmd_status), 64'd0);
         end else @(negedge clk);
      end
      check(got == 1, "R9 running erase completion seen", 64'(got), 64'd1);
      bus_read(11'h004, d, e, f, v);
      check(e, "R1 two-page erase cleared page 0", 64'(e), 64'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_program();
      t_zero_and_align();
      t_single();
      t_double();
      t_blank();
      t_mid_page_erase();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule